// File: doc/BRIEF.md
# Cycle-Counting Overcurrent Limiter

This block sits between the pulse-width modulator of a synchronous step-down converter and its gate drivers. It takes a digital flag from an external current-sense comparator. While the flag stays low, the high-side and low-side commands follow the PWM demand in a complementary way. When the flag rises, the block runs the converter in constant-current mode. It drops the high-side command and turns the low-side switch on in the same clock. It keeps the low side on until the next switching-cycle tick, or for as long as the flag stays high.

The block counts switching cycles in a row in which the flag was seen. When the count reaches a parameterised limit (seven by default), it latches a fault. The fault turns both switches off and stays set until the enable input goes low. A switching cycle is the span that ends at a clock edge where `cycleTick` is high. That tick clock belongs to the cycle it closes.

Top module: `ocl_limiter`

## Requirements
- R1: In a clock where the limiter is running (enabled, out of its start clock, no fault) and `ocFlag` is 1, `hsCmd` is 0 and `lsCmd` is 1 in that same clock, whatever `pwmDemand` is.
- R2: After `ocFlag` has been 1, the forced low-side state lasts up to and including the next clock in which `cycleTick` is 1, and ends in the clock after it. If `ocFlag` is 1 in a tick clock, forcing lasts through the whole following cycle, up to and including its tick clock.
- R3: When the tick clock closes the seventh cycle in a row that held at least one `ocFlag` clock, `faultLatched` reads 1 from the next clock on.
- R4: A cycle with no `ocFlag` clock sets the run of event cycles back to zero. Six event cycles, a clean cycle, then six more event cycles do not trip.
- R5: Any number of `ocFlag` pulses inside one cycle add only one to the run. Six cycles with four pulses each do not trip.
- R6: While `faultLatched` is 1, `hsCmd` and `lsCmd` are both 0, whatever `pwmDemand` and `ocFlag` are.
- R7: Once set, `faultLatched` stays 1 for as long as `enable` stays 1, across ticks and flag activity.
- R8: While `enable` is 0, or reset is held, or in the first clock after `enable` rises, both commands are 0. `faultLatched` reads 0 from the clock after `enable` is seen low.
- R9: While running with no forcing, `hsCmd` equals `pwmDemand` and `lsCmd` equals its inverse.
- R10: `hsCmd` and `lsCmd` are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; a low level clears the fault |
| cycleTick | input | 1 | One-clock strobe closing the current switching cycle |
| pwmDemand | input | 1 | High-side demand from the modulator |
| ocFlag | input | 1 | Overcurrent comparator output, 1 when over threshold |
| hsCmd | output | 1 | High-side switch command |
| lsCmd | output | 1 | Low-side switch command |
| faultLatched | output | 1 | Sticky overcurrent fault status |

## Verification
The bench goes after the clock where the flag drops in the middle of a cycle. A design that releases on the falling flag, rather than at the tick, would hand control back to the PWM too early. A flag in the tick clock itself must stretch forcing over the whole next cycle; a design that lets the clear win would lose it. Cycles with several pulses would trip a design that counts edges rather than cycles. A clean cycle between two runs of six would trip a design that never resets its count. The bench also checks that the fault stays off-off and sticky while enabled, and that it drops only after enable has been low for a clock.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  // Strobes from the control FSM to the event datapath
  typedef struct packed {
    logic clearAll;    // hold tracking state at zero
    logic closeCycle;  // current clock ends the switching cycle
  } ocl_strobe_t;
endpackage

// File: rtl/ocl_datapath.sv
module ocl_datapath
  import ocl_pkg::*;
#(
  parameter int TRIP_LIMIT = 7,
  localparam int CNT_W = $clog2(TRIP_LIMIT + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ocFlag,
  input  ocl_strobe_t strobe,
  output logic        forceLow,
  output logic        tripNow
);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(TRIP_LIMIT - 1);

  logic             forceHold;
  logic             eventSeen;
  logic [CNT_W-1:0] runCount;
  logic             cycleEvent;
  logic             atLimit;

  assign cycleEvent = eventSeen | ocFlag;
  assign atLimit    = (runCount == LAST_COUNT);
  assign forceLow   = ocFlag | forceHold;
  assign tripNow    = strobe.closeCycle & cycleEvent & atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceHold <= 1'b0;
      eventSeen <= 1'b0;
      runCount  <= '0;
    end else if (strobe.clearAll) begin
      forceHold <= 1'b0;
      eventSeen <= 1'b0;
      runCount  <= '0;
    end else begin
      // a flag in the closing clock wins over the release
      forceHold <= ocFlag | (forceHold & ~strobe.closeCycle);
      eventSeen <= cycleEvent & ~strobe.closeCycle;
      if (strobe.closeCycle) begin
        if (!cycleEvent || atLimit) runCount <= '0;
        else                        runCount <= runCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocl_ctrl.sv
module ocl_ctrl
  import ocl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cycleTick,
  input  logic        pwmDemand,
  input  logic        forceLow,
  input  logic        tripNow,
  output ocl_strobe_t strobe,
  output logic        hsCmd,
  output logic        lsCmd,
  output logic        faultLatched
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TRIP} state_e;

  state_e state, stateNext;
  logic   running;

  assign running = (state == ST_RUN) && enable;

  always_comb begin
    stateNext = state;
    if (!enable)                      stateNext = ST_IDLE;
    else if (state == ST_IDLE)        stateNext = ST_RUN;
    else if (state == ST_RUN && tripNow) stateNext = ST_TRIP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearAll   = !running;
    strobe.closeCycle = cycleTick;
    hsCmd = 1'b0;
    lsCmd = 1'b0;
    if (running) begin
      if (forceLow) begin
        lsCmd = 1'b1;
      end else begin
        hsCmd = pwmDemand;
        lsCmd = ~pwmDemand;
      end
    end
  end

  assign faultLatched = (state == ST_TRIP);
endmodule

// File: rtl/ocl_limiter.sv
module ocl_limiter
  import ocl_pkg::*;
#(
  parameter int TRIP_LIMIT = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic cycleTick,
  input  logic pwmDemand,
  input  logic ocFlag,
  output logic hsCmd,
  output logic lsCmd,
  output logic faultLatched
);
  ocl_strobe_t strobe;
  logic        forceLow;
  logic        tripNow;

  ocl_datapath #(.TRIP_LIMIT(TRIP_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .strobe(strobe),
    .forceLow(forceLow), .tripNow(tripNow)
  );

  ocl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cycleTick(cycleTick),
    .pwmDemand(pwmDemand), .forceLow(forceLow), .tripNow(tripNow),
    .strobe(strobe), .hsCmd(hsCmd), .lsCmd(lsCmd), .faultLatched(faultLatched)
  );
endmodule

// File: rtl/ocl_checker.sv
module ocl_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cycleTick,
  input logic pwmDemand,
  input logic ocFlag,
  input logic hsCmd,
  input logic lsCmd,
  input logic faultLatched
);
  // R1: flag with any drive active means low side only
  assert_flag_forces_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ocFlag && (hsCmd || lsCmd)) |-> (lsCmd && !hsCmd));

  // R2: forcing carries into the clock after a flag while still running
  assert_hold_after_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ocFlag && lsCmd && enable) |=> ((enable && !faultLatched) |-> (lsCmd && !hsCmd)));

  // R6: tripped state drives nothing
  assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!hsCmd && !lsCmd));

  // R7: fault sticky while enabled
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && enable) |=> faultLatched);

  // R8: disable clears the fault next clock
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !faultLatched);

  // R8: disabled means no drive
  assert_disabled_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!hsCmd && !lsCmd));

  // R10: never both switches on
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(hsCmd && lsCmd));

  // R3: fault appears only on a tick edge
  assert_trip_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> $past(cycleTick));
endmodule

bind ocl_limiter ocl_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .cycleTick(cycleTick),
  .pwmDemand(pwmDemand), .ocFlag(ocFlag), .hsCmd(hsCmd), .lsCmd(lsCmd),
  .faultLatched(faultLatched)
);

// File: tb/tb_ocl_limiter.sv
module tb_ocl_limiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic cycleTick = 1'b0;
  logic pwmDemand = 1'b0;
  logic ocFlag = 1'b0;
  logic hsCmd, lsCmd, faultLatched;

  always #10 clk = ~clk;  // 50 MHz

  ocl_limiter dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cycleTick(cycleTick),
    .pwmDemand(pwmDemand), .ocFlag(ocFlag), .hsCmd(hsCmd), .lsCmd(lsCmd),
    .faultLatched(faultLatched)
  );

  typedef struct {
    logic  hs;
    logic  ls;
    logic  f;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   nTests = 0;
  int   nFail  = 0;
  bit   finished = 1'b0;

  // reference model state (0 idle, 1 run, 2 tripped)
  int   mState = 0;
  bit   mHold = 0, mSeen = 0;
  int   mCnt = 0;

  task automatic step(input logic rst, input logic en, input logic tk,
                      input logic pwm, input logic oc, input string tag);
    exp_t e;
    bit   run;
    bit   ev;
    @(negedge clk);
    rstN = rst; enable = en; cycleTick = tk; pwmDemand = pwm; ocFlag = oc;
    run = (mState == 1) && en && rst;
    e.tag = tag;
    e.f   = rst && (mState == 2);
    if (!run)              begin e.hs = 0; e.ls = 0; end
    else if (oc || mHold)  begin e.hs = 0; e.ls = 1; end
    else                   begin e.hs = pwm; e.ls = ~pwm; end
    expQ.push_back(e);
    @(posedge clk);
    if (!rst || !en) begin
      mState = 0; mHold = 0; mSeen = 0; mCnt = 0;
    end else if (mState == 0) begin
      mState = 1; mHold = 0; mSeen = 0; mCnt = 0;
    end else if (mState == 1) begin
      ev = mSeen || oc;
      if (tk && ev && mCnt == 6) begin
        mState = 2; mHold = 0; mSeen = 0; mCnt = 0;
      end else begin
        if (tk) mCnt = ev ? mCnt + 1 : 0;
        mHold = oc ? 1'b1 : (tk ? 1'b0 : mHold);
        mSeen = tk ? 1'b0 : ev;
      end
    end
  endtask

  task automatic cycle8(input logic [7:0] ocMask, input logic [7:0] pwmMask,
                        input string tag);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, i == 7, pwmMask[i], ocMask[i], tag);
  endtask

  // monitor: compare away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() != 0) begin
        e = expQ.pop_front();
        nTests++;
        if (hsCmd !== e.hs || lsCmd !== e.ls || faultLatched !== e.f) begin
          nFail++;
          $display("FAIL %s: got hs=%b ls=%b f=%b expected hs=%b ls=%b f=%b",
                   e.tag, hsCmd, lsCmd, faultLatched, e.hs, e.ls, e.f);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R8: reset and disable keep drives off
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8");  // start clock
    // R9, R10: complementary follow
    cycle8(8'h00, 8'b00001111, "R9/R10");
    cycle8(8'h00, 8'b10100110, "R9/R10");
    // R1, R2: mid-cycle pulse forces until the tick
    cycle8(8'b00000100, 8'hFF, "R1/R2");
    cycle8(8'h00, 8'hFF, "R2");
    // R5: many pulses per cycle count once
    for (int c = 0; c < 6; c++) cycle8(8'b01010101, 8'hF0, "R5");
    // R4: clean cycle restarts the run
    cycle8(8'h00, 8'hF0, "R4");
    for (int c = 0; c < 6; c++) cycle8(8'b00000001, 8'hFF, "R4");
    cycle8(8'h00, 8'hFF, "R4");
    // R3: seventh event cycle trips
    for (int c = 0; c < 7; c++) cycle8(8'b00100000, 8'hFF, "R3");
    // R6, R7: tripped and sticky
    cycle8(8'b00010001, 8'hFF, "R6/R7");
    cycle8(8'h00, 8'hFF, "R6/R7");
    // R8: disable clears, restart
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    cycle8(8'h00, 8'b11001100, "R8/R9");
    // R2: flag in the tick clock forces the whole next cycle
    cycle8(8'b10000000, 8'hFF, "R2");
    cycle8(8'h00, 8'hFF, "R2");
    cycle8(8'h00, 8'hFF, "R2/R9");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule